// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns the operand bytes of an 8-bit controller instruction into the location the instruction works on. A mode code selects one of seven addressing forms. Three of them name registers in a 128-byte register file: a single register, a source/destination pair, or a register pair that holds a pointer. One names an 8-bit peripheral port. Two build a 16-bit memory address: a direct address, or a direct address offset by the B register. The last builds a branch target relative to the address of the next instruction.

The decode stage supplies these inputs: the mode, the first and second bytes after the opcode, the B register, and the two register bytes read for a pointer access. For a pointer access the decode stage reads the register file at the two indices this unit reports and feeds the bytes back. Each output group has its own valid flag. A data output whose flag is low reads zero. A parameter adds an output register, which gives one cycle of latency. The default build has this register.

Top module: `opnd_ea_unit`

## Requirements
- R1: Mode 3 (direct) gives a memory address with operand byte 1 as the high byte and operand byte 2 as the low byte. The B register and the pointer bytes have no effect on it.
- R2: Mode 4 (register pointer) reports register n (byte 1) as the first index and register n-1 as the second index. The memory address takes its high byte from register n-1 and its low byte from register n.
- R3: In mode 4 with n equal to 0, the second index is 127, the top of the register file, and not 255.
- R4: Mode 5 (indexed) gives the direct address plus the unsigned B register. A carry out of the low byte raises the high byte.
- R5: Every 16-bit sum wraps modulo 65536 and raises no fault. For example, 0xFFFF plus 1 gives 0x0000, and 0xFFFE plus 5 gives 0x0003.
- R6: Mode 6 (relative) gives a branch target equal to the next-instruction address plus operand byte 1 read as a signed two's-complement offset.
- R7: Mode 0 (single register) reports byte 1 as the first index. Mode 1 (register pair) also reports byte 2 as the second index. Bit 7 of an index byte is ignored.
- R8: Mode 2 (peripheral) reports byte 1 as an 8-bit port number. No register or memory flag is raised with it.
- R9: Valid flags are set as follows. The memory flag is high in modes 3, 4 and 5. The first index flag is high in modes 0, 1 and 4. The second index flag is high in modes 1 and 4. The port flag is high in mode 2. The branch flag is high in mode 6. Mode 7, or a low input-valid, raises no flag, and every data output whose flag is low reads zero.
- R10: With the output register built, a result appears on the outputs after the first rising clock edge that follows the input. An active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an instruction to resolve |
| mode | input | 3 | Addressing mode code, 0 to 7 |
| opnd1 | input | 8 | First byte after the opcode |
| opnd2 | input | 8 | Second byte after the opcode |
| breg | input | 8 | Contents of the B register |
| ptr_lo | input | 8 | Register byte read at the first index (pointer low) |
| ptr_hi | input | 8 | Register byte read at the second index (pointer high) |
| npc | input | 16 | Address of the next instruction |
| mem_addr | output | 16 | Effective memory address |
| mem_vld | output | 1 | Memory address is valid |
| reg_idx | output | 7 | First register-file index |
| reg_idx_vld | output | 1 | First index is valid |
| reg_idx2 | output | 7 | Second register-file index |
| reg_idx2_vld | output | 1 | Second index is valid |
| port_num | output | 8 | Peripheral port number |
| port_vld | output | 1 | Port number is valid |
| br_target | output | 16 | Relative branch target |
| br_vld | output | 1 | Branch target is valid |

## Verification
In indexed mode, the carry from the low byte into the high byte and the wrap of the whole 16-bit sum can happen in one addition. A base of 0xFFFF plus a B value of 1 triggers both, and the expected result is exactly 0x0000 with the memory flag high. In the pointer mode, the companion-index wrap and the address assembly also happen in the same cycle. Register 0, and register 0x80 with its ignored top bit, are each checked for index 127 together with the full assembled address. Each table row is compared on all outputs at once, so a result that leaks into a neighbouring output group is caught in the same comparison.

// File: rtl/oa_pkg.sv
package oa_pkg;

   typedef enum logic [2:0] {
      AM_REG1    = 3'd0,
      AM_REG2    = 3'd1,
      AM_PORT    = 3'd2,
      AM_DIRECT  = 3'd3,
      AM_PTR     = 3'd4,
      AM_INDEXED = 3'd5,
      AM_PCREL   = 3'd6,
      AM_NONE    = 3'd7
   } amode_e;

endpackage

// File: rtl/oa_reg_index.sv
module oa_reg_index #(
   parameter int DW       = 8,
   parameter int RF_DEPTH = 128,
   localparam int RIW     = $clog2(RF_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sel_single,
   input  logic           sel_dual,
   input  logic           sel_pair,
   input  logic [DW-1:0]  byte_a,
   input  logic [DW-1:0]  byte_b,
   output logic [RIW-1:0] idx_a,
   output logic [RIW-1:0] idx_b,
   output logic           vld_a,
   output logic           vld_b
);

   logic [RIW-1:0] rn_a;
   logic [RIW-1:0] rn_b;
   logic [RIW-1:0] companion;

   generate
      if (RF_DEPTH < 2 || RF_DEPTH > (1 << DW)) begin : g_bad_depth
         $error("oa_reg_index: RF_DEPTH must lie between 2 and 2**DW");
      end
   endgenerate

   assign rn_a = byte_a[RIW-1:0];
   assign rn_b = byte_b[RIW-1:0];

   generate
      if (RIW < DW) begin : g_spare_bits
         logic unused_hi;
         assign unused_hi = ^{byte_a[DW-1:RIW], byte_b[DW-1:RIW]};
      end
   endgenerate

   // companion register sits one below; index 0 folds to the top entry
   generate
      if ((1 << RIW) == RF_DEPTH) begin : g_pow2
         assign companion = rn_a - RIW'(1);
      end else begin : g_cmp
         assign companion = (rn_a == '0) ? RIW'(RF_DEPTH - 1) : rn_a - RIW'(1);
      end
   endgenerate

   always_comb begin
      vld_a = sel_single | sel_dual | sel_pair;
      vld_b = sel_dual | sel_pair;
      idx_a = vld_a ? rn_a : '0;
      if (sel_pair)
         idx_b = companion;
      else if (sel_dual)
         idx_b = rn_b;
      else
         idx_b = '0;
   end

   // R3
   pair_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pair && idx_a == '0) |-> (idx_b == RIW'(RF_DEPTH - 1)));

   // R2
   pair_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pair && idx_a != '0) |-> (RIW'(idx_b + RIW'(1)) == idx_a));

endmodule

// File: rtl/oa_mem_addr.sv
module oa_mem_addr #(
   parameter int DW          = 8,
   parameter int AW          = 16,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_direct,
   input  logic          sel_indexed,
   input  logic          sel_pair,
   input  logic [DW-1:0] hi_byte,
   input  logic [DW-1:0] lo_byte,
   input  logic [DW-1:0] index,
   input  logic [DW-1:0] ptr_lo,
   input  logic [DW-1:0] ptr_hi,
   output logic [AW-1:0] addr,
   output logic          vld
);

   logic [AW-1:0] base;
   logic [AW-1:0] indexed_sum;

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("oa_mem_addr: AW must be twice DW");
      end
   endgenerate

   assign base = {hi_byte, lo_byte};

   generate
      if (SPLIT_CARRY) begin : g_split
         logic [DW:0] lo_sum;
         assign lo_sum      = {1'b0, lo_byte} + {1'b0, index};
         assign indexed_sum = {hi_byte + DW'(lo_sum[DW]), lo_sum[DW-1:0]};
      end else begin : g_flat
         assign indexed_sum = base + AW'(index);
      end
   endgenerate

   always_comb begin
      vld  = sel_direct | sel_indexed | sel_pair;
      addr = '0;
      if (sel_direct)
         addr = base;
      else if (sel_indexed)
         addr = indexed_sum;
      else if (sel_pair)
         addr = {ptr_hi, ptr_lo};
   end

   // R4
   index_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_indexed |-> (AW'(addr - base) == AW'(index)));

   // R5
   index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_indexed && (base == '1) && (index == DW'(1))) |-> (addr == '0));

endmodule

// File: rtl/oa_branch.sv
module oa_branch #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic [AW-1:0] npc,
   input  logic [DW-1:0] offs,
   output logic [AW-1:0] target,
   output logic          vld
);

   logic [AW-1:0] disp;

   generate
      if (AW <= DW) begin : g_bad_width
         $error("oa_branch: AW must exceed DW");
      end
   endgenerate

   assign disp = {{(AW - DW){offs[DW-1]}}, offs};

   always_comb begin
      vld    = sel;
      target = sel ? AW'(npc + disp) : '0;
   end

   // R6
   fwd_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !offs[DW-1]) |-> (AW'(target - npc) < AW'(1 << (DW - 1))));

   // R6
   back_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && offs[DW-1]) |->
         ((AW'(npc - target) <= AW'(1 << (DW - 1))) && (target != npc)));

endmodule

// File: rtl/oa_out_stage.sv
module oa_out_stage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("oa_out_stage: W must be positive");
      end
   endgenerate

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else
               q <= d;
         end
      end else begin : g_wire
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit #(
   parameter int DW          = 8,
   parameter int AW          = 16,
   parameter int RF_DEPTH    = 128,
   parameter bit OUT_REG     = 1'b1,
   parameter bit SPLIT_CARRY = 1'b1,
   localparam int RIW        = $clog2(RF_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [2:0]     mode,
   input  logic [DW-1:0]  opnd1,
   input  logic [DW-1:0]  opnd2,
   input  logic [DW-1:0]  breg,
   input  logic [DW-1:0]  ptr_lo,
   input  logic [DW-1:0]  ptr_hi,
   input  logic [AW-1:0]  npc,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_vld,
   output logic [RIW-1:0] reg_idx,
   output logic           reg_idx_vld,
   output logic [RIW-1:0] reg_idx2,
   output logic           reg_idx2_vld,
   output logic [DW-1:0]  port_num,
   output logic           port_vld,
   output logic [AW-1:0]  br_target,
   output logic           br_vld
);
   import oa_pkg::*;

   localparam int BUS_W = 2 * AW + 2 * RIW + DW + 5;

   amode_e am;
   logic   s_reg1, s_reg2, s_port, s_direct, s_ptr, s_indexed, s_pcrel;

   logic [AW-1:0]  c_addr;
   logic           c_addr_vld;
   logic [RIW-1:0] c_idx_a, c_idx_b;
   logic           c_idx_a_vld, c_idx_b_vld;
   logic [DW-1:0]  c_port;
   logic [AW-1:0]  c_br;
   logic           c_br_vld;
   logic [BUS_W-1:0] c_bus, q_bus;

   assign am = amode_e'(mode);

   always_comb begin
      s_reg1    = in_valid && (am == AM_REG1);
      s_reg2    = in_valid && (am == AM_REG2);
      s_port    = in_valid && (am == AM_PORT);
      s_direct  = in_valid && (am == AM_DIRECT);
      s_ptr     = in_valid && (am == AM_PTR);
      s_indexed = in_valid && (am == AM_INDEXED);
      s_pcrel   = in_valid && (am == AM_PCREL);
   end

   oa_reg_index #(.DW(DW), .RF_DEPTH(RF_DEPTH)) u_idx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_single (s_reg1),
      .sel_dual   (s_reg2),
      .sel_pair   (s_ptr),
      .byte_a     (opnd1),
      .byte_b     (opnd2),
      .idx_a      (c_idx_a),
      .idx_b      (c_idx_b),
      .vld_a      (c_idx_a_vld),
      .vld_b      (c_idx_b_vld)
   );

   oa_mem_addr #(.DW(DW), .AW(AW), .SPLIT_CARRY(SPLIT_CARRY)) u_mem (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_direct  (s_direct),
      .sel_indexed (s_indexed),
      .sel_pair    (s_ptr),
      .hi_byte     (opnd1),
      .lo_byte     (opnd2),
      .index       (breg),
      .ptr_lo      (ptr_lo),
      .ptr_hi      (ptr_hi),
      .addr        (c_addr),
      .vld         (c_addr_vld)
   );

   oa_branch #(.DW(DW), .AW(AW)) u_br (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (s_pcrel),
      .npc    (npc),
      .offs   (opnd1),
      .target (c_br),
      .vld    (c_br_vld)
   );

   assign c_port = s_port ? opnd1 : '0;

   assign c_bus = {c_addr, c_addr_vld, c_idx_a, c_idx_a_vld, c_idx_b, c_idx_b_vld,
                   c_port, s_port, c_br, c_br_vld};

   oa_out_stage #(.W(BUS_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (c_bus),
      .q     (q_bus)
   );

   assign {mem_addr, mem_vld, reg_idx, reg_idx_vld, reg_idx2, reg_idx2_vld,
           port_num, port_vld, br_target, br_vld} = q_bus;

   // R9
   vld_group_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({port_vld, br_vld, mem_vld | reg_idx_vld}));

   // R9
   idx2_needs_idx1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_idx2_vld |-> reg_idx_vld);

   // R8
   port_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_vld |-> (!mem_vld && !reg_idx_vld && !reg_idx2_vld));

   generate
      if (OUT_REG) begin : g_lat_chk
         // R10
         idle_next_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !(mem_vld || reg_idx_vld || reg_idx2_vld || port_vld || br_vld));
      end
   endgenerate

endmodule

// File: tb/opnd_ea_unit_test.sv
`timescale 1ns/1ps
module opnd_ea_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = 3'd7;
   logic [7:0]  opnd1 = '0, opnd2 = '0, breg = '0, ptr_lo = '0, ptr_hi = '0;
   logic [15:0] npc = '0;
   logic [15:0] mem_addr, br_target;
   logic        mem_vld, reg_idx_vld, reg_idx2_vld, port_vld, br_vld;
   logic [6:0]  reg_idx, reg_idx2;
   logic [7:0]  port_num;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   opnd_ea_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .opnd1(opnd1), .opnd2(opnd2), .breg(breg), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
      .npc(npc), .mem_addr(mem_addr), .mem_vld(mem_vld), .reg_idx(reg_idx),
      .reg_idx_vld(reg_idx_vld), .reg_idx2(reg_idx2), .reg_idx2_vld(reg_idx2_vld),
      .port_num(port_num), .port_vld(port_vld), .br_target(br_target), .br_vld(br_vld)
   );

   // fields: mode, b1, b2, breg, lo, hi, npc | exp mem, idx, idx2, port, br, flags{mem,idx,idx2,port,br}
   localparam int NV = 18;
   localparam logic [117:0] TBL [0:NV-1] = '{
      // R1 plain direct
      {3'd3, 8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h1234, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b10000},
      // R1 direct ignores B and pointer bytes
      {3'd3, 8'hFF, 8'h00, 8'h77, 8'h55, 8'h66, 16'hAAAA, 16'hFF00, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b10000},
      // R2 pointer at register 5
      {3'd4, 8'h05, 8'h00, 8'h00, 8'hCD, 8'hAB, 16'h0000, 16'hABCD, 7'h05, 7'h04, 8'h00, 16'h0000, 5'b11100},
      // R2 pointer at register 127
      {3'd4, 8'h7F, 8'h00, 8'h99, 8'h3C, 8'hC3, 16'h0000, 16'hC33C, 7'h7F, 7'h7E, 8'h00, 16'h0000, 5'b11100},
      // R3 pointer at register 0 wraps companion to 127
      {3'd4, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 16'h0000, 16'h2211, 7'h00, 7'h7F, 8'h00, 16'h0000, 5'b11100},
      // R3 R7 byte 0x80 names register 0
      {3'd4, 8'h80, 8'h00, 8'h00, 8'h01, 8'h02, 16'h0000, 16'h0201, 7'h00, 7'h7F, 8'h00, 16'h0000, 5'b11100},
      // R4 low-byte carry into high byte
      {3'd5, 8'h12, 8'hF0, 8'h20, 8'h00, 8'h00, 16'h0000, 16'h1310, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b10000},
      // R4 no carry, B is unsigned
      {3'd5, 8'h40, 8'h00, 8'hFF, 8'h00, 8'h00, 16'h0000, 16'h40FF, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b10000},
      // R5 indexed carry and 16-bit wrap together
      {3'd5, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00, 16'h0000, 16'h0000, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b10000},
      // R6 forward
      {3'd6, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h0000, 7'h00, 7'h00, 8'h00, 16'h1010, 5'b00001},
      // R6 most negative offset
      {3'd6, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h0000, 7'h00, 7'h00, 8'h00, 16'h0F80, 5'b00001},
      // R6 largest positive offset
      {3'd6, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h0000, 7'h00, 7'h00, 8'h00, 16'h107F, 5'b00001},
      // R5 backward wrap below zero
      {3'd6, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0005, 16'h0000, 7'h00, 7'h00, 8'h00, 16'hFFF5, 5'b00001},
      // R5 forward wrap above 0xFFFF
      {3'd6, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFFE, 16'h0000, 7'h00, 7'h00, 8'h00, 16'h0003, 5'b00001},
      // R7 single register, bit 7 ignored
      {3'd0, 8'h85, 8'h33, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 7'h05, 7'h00, 8'h00, 16'h0000, 5'b01000},
      // R7 source and destination
      {3'd1, 8'h03, 8'hFE, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 7'h03, 7'h7E, 8'h00, 16'h0000, 5'b01100},
      // R8 port number keeps all 8 bits
      {3'd2, 8'hA5, 8'h5A, 8'h44, 8'h00, 8'h00, 16'h0000, 16'h0000, 7'h00, 7'h00, 8'hA5, 16'h0000, 5'b00010},
      // R9 unused mode code
      {3'd7, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 16'h1234, 16'h0000, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b00000}
   };

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'd0, 3'd1: return "R7";
         3'd2:       return "R8";
         3'd3:       return "R1";
         3'd4:       return "R2";
         3'd5:       return "R4";
         3'd6:       return "R6";
         default:    return "R9";
      endcase
   endfunction

   function automatic logic [58:0] outs();
      return {mem_addr, reg_idx, reg_idx2, port_num, br_target,
              mem_vld, reg_idx_vld, reg_idx2_vld, port_vld, br_vld};
   endfunction

   task automatic chk(input string tag, input string what, input logic [58:0] act, input logic [58:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] m, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] bb, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [15:0] pc);
      in_valid = v; mode = m; opnd1 = b1; opnd2 = b2; breg = bb; ptr_lo = lo; ptr_hi = hi; npc = pc;
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      drive(1'b1, 3'd3, 8'hDE, 8'hAD, 8'h00, 8'h00, 8'h00, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R10", "outputs under reset", outs(), '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(1'b1, TBL[i][117:115], TBL[i][114:107], TBL[i][106:99], TBL[i][98:91],
               TBL[i][90:83], TBL[i][82:75], TBL[i][74:59]);
         @(negedge clk);
         chk(tag_of(TBL[i][117:115]), $sformatf("table row %0d", i), outs(), TBL[i][58:0]);
      end

      // R9 in_valid low suppresses every output
      @(negedge clk);
      drive(1'b0, 3'd3, 8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 16'h0000);
      @(negedge clk);
      chk("R9", "in_valid low", outs(), '0);

      // R10 one cycle of latency
      drive(1'b1, 3'd3, 8'hBE, 8'hEF, 8'h00, 8'h00, 8'h00, 16'h0000);
      #1;
      chk("R10", "before edge", outs(), '0);
      @(negedge clk);
      chk("R10", "after edge", outs(), {16'hBEEF, 7'h00, 7'h00, 8'h00, 16'h0000, 5'b10000});

      // R10 reset clears a live result
      rst_n = 1'b0;
      #1;
      chk("R10", "reset mid-run", outs(), '0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule